// File: doc/BRIEF.md
# Idle-Time Driven DVFS Governor

This block chooses the operating point of a single processor from how idle that processor has been. A monitor hands it one idle-time sample at a fixed short interval. The block holds the recent samples in a shift history and keeps two running means over them. The short window follows load increases quickly. The long window reacts slowly to reduced load. Each mean is compared with a threshold that software programs. The block then asks the voltage regulator and clock generator for one step up or one step down among three operating points: low (0.8 V), medium (1.0 V) and high.

Software writes the two thresholds and the settling time, then asserts the active-low run request pin. From then on the block steers the level with no further register traffic. Every step loads a settling timer. No new step is taken until that timer has run out. Its expiry sets a sticky interrupt bit, which software clears by writing a one to it.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is held high, so every cycle with `smp_valid` high hands over exactly one sample. Configuration and status use a plain single-cycle write strobe with a combinational read port.

Top module: `dvfs_idle_governor`

## Requirements
- R1: `smp_ready` is high in every cycle, and each rising edge with `smp_valid` high takes in one sample from `smp_idle`.
- R2: The short mean is the sum of the latest 2^LOG2_N samples shifted right by LOG2_N. The long mean is the sum of the latest 2^LOG2_M samples shifted right by LOG2_M. No step decision is made until 2^LOG2_M samples have been taken since reset.
- R3: A decision steps the level down by one when the long mean is strictly greater than the down threshold (register 0). At the low level this step is suppressed.
- R4: A decision steps the level up by one when the short mean is strictly less than the up threshold (register 1). At the high level this step is suppressed. When both conditions hold, the up condition wins and no down step occurs.
- R5: The level output `lvl_req` uses code 0 for low (0.8 V), 1 for medium (1.0 V) and 2 for high. It resets to 2, never shows 3, and changes by at most one code per cycle.
- R6: Steps happen only while `run_req_n` is low and both threshold registers have been written since reset. Otherwise samples leave the level unchanged.
- R7: A decision is taken on the rising edge that follows the edge that accepted the sample. A step loads the settling timer with register 2, where a value of 0 counts as 1. While the timer is nonzero, decisions are skipped, but the means keep updating.
- R8: The timer expires on the edge where it goes from 1 to 0. That edge sets the sticky `irq` and bit 0 of register 3. Writing 1 to bit 0 of register 3 clears it. If an expiry and a clear fall on the same edge, the expiry wins.
- R9: Reads return the zero-extended register value: register 0 is the down threshold, 1 the up threshold, 2 the settle count, 3 the interrupt in bit 0, and 4 the level in bits 1:0 with the active state (armed and run requested) in bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Idle-time sample valid |
| smp_ready | output | 1 | Sample ready, always high |
| smp_idle | input | SAMPLE_W | Idle-time sample value |
| run_req_n | input | 1 | Active-low request for autonomous scaling |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| lvl_req | output | 2 | Requested operating point code |
| irq | output | 1 | Sticky settle-done interrupt |

## Verification
The bench builds the block with LOG2_N=1 and LOG2_M=2, so the windows are two and four samples, with SAMPLE_W=8 and TIMER_W=8. With these values the long window fills after four samples, and a few samples move the level across all three points in both directions. Settle counts of 0, 3 and 7, combined with varying idle gaps, place samples both inside and outside the settling window. This exercises the timer-blocked decisions, the floor and ceiling suppression and the up-over-down priority against a reference model in the bench that works on the arithmetic means.

// File: rtl/dvfs_gov_pkg.sv
package dvfs_gov_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam logic [2:0] ADDR_THR_DN = 3'd0;
  localparam logic [2:0] ADDR_THR_UP = 3'd1;
  localparam logic [2:0] ADDR_SETTLE = 3'd2;
  localparam logic [2:0] ADDR_STAT   = 3'd3;
  localparam logic [2:0] ADDR_LEVEL  = 3'd4;
endpackage

// File: rtl/dvfs_idle_avg.sv
module dvfs_idle_avg #(
  parameter int SAMPLE_W   = 8,
  parameter int LOG2_N     = 1,
  parameter int LOG2_M     = 2,
  parameter int HIST_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_fire,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [SAMPLE_W-1:0] avg_short,
  output logic [SAMPLE_W-1:0] avg_long,
  output logic                decide
);
  localparam int WIN_N  = 1 << LOG2_N;
  localparam int WIN_M  = 1 << LOG2_M;
  localparam int SUM_W  = SAMPLE_W + LOG2_M;
  localparam int FILL_W = $clog2(WIN_M + 1);

  // shift history, newest sample in stage 0
  for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_hist
    logic [SAMPLE_W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (smp_fire) q <= smp_data;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (smp_fire) q <= g_hist[g-1].q;
      end
    end
  end

  logic [SUM_W-1:0]  sum_n_q, sum_m_q;
  logic [SUM_W-1:0]  ext_new, leave_n, leave_m;
  logic [FILL_W-1:0] fill_q;
  logic              taken_q;
  logic              full;

  assign ext_new = SUM_W'(smp_data);
  assign leave_n = SUM_W'(g_hist[WIN_N-1].q);
  assign leave_m = SUM_W'(g_hist[WIN_M-1].q);
  assign full    = (fill_q == FILL_W'(WIN_M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_n_q <= '0;
      sum_m_q <= '0;
      fill_q  <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= smp_fire;
      if (smp_fire) begin
        sum_n_q <= sum_n_q + ext_new - leave_n;
        sum_m_q <= sum_m_q + ext_new - leave_m;
        if (!full) fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign avg_short = SAMPLE_W'(sum_n_q >> LOG2_N);
  assign avg_long  = SAMPLE_W'(sum_m_q >> LOG2_M);
  assign decide    = taken_q & full;
endmodule

// File: rtl/dvfs_step_ctrl.sv
module dvfs_step_ctrl
  import dvfs_gov_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TIMER_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                decide,
  input  logic                active,
  input  logic [SAMPLE_W-1:0] avg_short,
  input  logic [SAMPLE_W-1:0] avg_long,
  input  logic [SAMPLE_W-1:0] thr_dn,
  input  logic [SAMPLE_W-1:0] thr_up,
  input  logic [TIMER_W-1:0]  settle,
  output lvl_e                level,
  output logic                busy,
  output logic                expire
);
  lvl_e               level_q;
  logic [TIMER_W-1:0] timer_q;
  logic [TIMER_W-1:0] settle_eff;
  logic               up_cond, dn_cond, may_decide;
  step_e              step;

  assign settle_eff = (settle == '0) ? TIMER_W'(1) : settle;
  assign busy       = (timer_q != '0);
  assign expire     = (timer_q == TIMER_W'(1));
  assign up_cond    = (avg_short < thr_up);
  assign dn_cond    = (avg_long > thr_dn);
  assign may_decide = decide & active & ~busy;

  always_comb begin
    step = STEP_NONE;
    if (may_decide) begin
      if (up_cond) begin
        if (level_q != LVL_HIGH) step = STEP_UP;
      end else if (dn_cond && level_q != LVL_LOW) begin
        step = STEP_DOWN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_HIGH;
      timer_q <= '0;
    end else begin
      unique case (step)
        STEP_UP:   level_q <= lvl_e'(level_q + 2'd1);
        STEP_DOWN: level_q <= lvl_e'(level_q - 2'd1);
        default:   level_q <= level_q;
      endcase
      if (step != STEP_NONE) timer_q <= settle_eff;
      else if (busy)         timer_q <= timer_q - 1'b1;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/dvfs_cfg_regs.sv
module dvfs_cfg_regs
  import dvfs_gov_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TIMER_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic                irq_clr,
  input  logic                expire,
  input  lvl_e                level,
  input  logic                active,
  output logic [SAMPLE_W-1:0] thr_dn,
  output logic [SAMPLE_W-1:0] thr_up,
  output logic [TIMER_W-1:0]  settle,
  output logic                armed,
  output logic                irq,
  output logic [31:0]         cfg_rdata
);
  logic dn_set_q, up_set_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_dn   <= '0;
      thr_up   <= '0;
      settle   <= '0;
      dn_set_q <= 1'b0;
      up_set_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_THR_DN: begin
          thr_dn   <= cfg_wdata[SAMPLE_W-1:0];
          dn_set_q <= 1'b1;
        end
        ADDR_THR_UP: begin
          thr_up   <= cfg_wdata[SAMPLE_W-1:0];
          up_set_q <= 1'b1;
        end
        ADDR_SETTLE: settle <= cfg_wdata[TIMER_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (expire)  irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  always_comb begin
    case (cfg_addr)
      ADDR_THR_DN: cfg_rdata = 32'(thr_dn);
      ADDR_THR_UP: cfg_rdata = 32'(thr_up);
      ADDR_SETTLE: cfg_rdata = 32'(settle);
      ADDR_STAT:   cfg_rdata = {31'b0, irq_q};
      ADDR_LEVEL:  cfg_rdata = {29'b0, active, level};
      default:     cfg_rdata = '0;
    endcase
  end

  assign armed = dn_set_q & up_set_q;
  assign irq   = irq_q;
endmodule

// File: rtl/dvfs_idle_governor.sv
module dvfs_idle_governor
  import dvfs_gov_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int TIMER_W    = 16,
  parameter int LOG2_N     = 1,
  parameter int LOG2_M     = 2,
  parameter int HIST_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_idle,
  input  logic                run_req_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [1:0]          lvl_req,
  output logic                irq
);
  logic [SAMPLE_W-1:0] avg_short_w, avg_long_w, thr_dn_w, thr_up_w;
  logic [TIMER_W-1:0]  settle_w;
  logic                decide_w, busy_w, expire_w, armed_w, active_w, irq_clr_w;
  lvl_e                level_w;

  assign smp_ready = 1'b1;
  assign active_w  = armed_w & ~run_req_n;
  assign irq_clr_w = cfg_we & (cfg_addr == ADDR_STAT) & cfg_wdata[0];

  dvfs_idle_avg #(
    .SAMPLE_W(SAMPLE_W), .LOG2_N(LOG2_N), .LOG2_M(LOG2_M), .HIST_DEPTH(HIST_DEPTH)
  ) avg_i (
    .clk(clk), .rst_n(rst_n),
    .smp_fire(smp_valid & smp_ready), .smp_data(smp_idle),
    .avg_short(avg_short_w), .avg_long(avg_long_w), .decide(decide_w)
  );

  dvfs_step_ctrl #(.SAMPLE_W(SAMPLE_W), .TIMER_W(TIMER_W)) step_i (
    .clk(clk), .rst_n(rst_n), .decide(decide_w), .active(active_w),
    .avg_short(avg_short_w), .avg_long(avg_long_w),
    .thr_dn(thr_dn_w), .thr_up(thr_up_w), .settle(settle_w),
    .level(level_w), .busy(busy_w), .expire(expire_w)
  );

  dvfs_cfg_regs #(.SAMPLE_W(SAMPLE_W), .TIMER_W(TIMER_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_clr(irq_clr_w), .expire(expire_w),
    .level(level_w), .active(active_w),
    .thr_dn(thr_dn_w), .thr_up(thr_up_w), .settle(settle_w),
    .armed(armed_w), .irq(irq), .cfg_rdata(cfg_rdata)
  );

  assign lvl_req = level_w;
endmodule

// File: rtl/dvfs_gov_checker.sv
module dvfs_gov_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] level,
  input logic       busy,
  input logic       active,
  input logic       irq,
  input logic       irq_clr,
  input logic       decide
);
  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'd3); // R5
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    level != $past(level) |-> (level == $past(level) + 2'd1) || (level + 2'd1 == $past(level))); // R5
  AST_NO_STEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(level)); // R7
  AST_STEP_ARMS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    level != $past(level) |-> busy); // R7
  AST_IDLE_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(level)); // R6
  AST_NO_STEP_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> $stable(level)); // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R8
endmodule

bind dvfs_idle_governor dvfs_gov_checker chk_i (
  .clk(clk), .rst_n(rst_n), .level(lvl_req), .busy(busy_w), .active(active_w),
  .irq(irq), .irq_clr(irq_clr_w), .decide(decide_w)
);

// File: tb/dvfs_idle_governor_tb_top.sv
module dvfs_idle_governor_tb_top;
  localparam int SW = 8;
  localparam int TW = 8;
  localparam int LN = 1;
  localparam int LM = 2;
  localparam int NWIN = 1 << LN;
  localparam int MWIN = 1 << LM;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [SW-1:0] smp_idle = '0;
  logic        run_req_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  lvl_req;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_hist[16];
  int m_fill = 0, m_level = 2, m_timer = 0, m_irq = 0;
  int m_thr_dn = 0, m_thr_up = 0, m_settle = 0;
  bit m_dn_set = 0, m_up_set = 0;

  always #4 clk = ~clk;

  dvfs_idle_governor #(
    .SAMPLE_W(SW), .TIMER_W(TW), .LOG2_N(LN), .LOG2_M(LM), .HIST_DEPTH(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_idle(smp_idle), .run_req_n(run_req_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lvl_req(lvl_req), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int win_mean(input int len);
    int s = 0;
    for (int k = 0; k < len; k++) s += m_hist[k];
    return s / len;
  endfunction

  // one rising edge plus the reference model update; returns at the next falling edge
  task automatic edge_step(input bit dec, input bit clr, input bit smp, input int sval);
    bit exp_now;
    bit stepped;
    @(posedge clk);
    exp_now = (m_timer == 1);
    stepped = 0;
    if (dec && m_dn_set && m_up_set && !run_req_n && m_timer == 0 && m_fill == MWIN) begin
      if (win_mean(NWIN) < m_thr_up) begin
        if (m_level < 2) begin m_level++; stepped = 1; end
      end else if (win_mean(MWIN) > m_thr_dn && m_level > 0) begin
        m_level--; stepped = 1;
      end
    end
    if (stepped) m_timer = (m_settle == 0) ? 1 : m_settle;
    else if (m_timer > 0) m_timer--;
    if (exp_now) m_irq = 1;
    else if (clr) m_irq = 0;
    if (smp) begin
      for (int k = 15; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = sval;
      if (m_fill < MWIN) m_fill++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) edge_step(0, 0, 0, 0);
  endtask

  task automatic send(input int s, input string req);
    smp_valid = 1'b1;
    smp_idle  = SW'(s);
    edge_step(0, 0, 1, s);
    smp_valid = 1'b0;
    edge_step(1, 0, 0, 0);
    chk(req, lvl_req, m_level);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    bit clr;
    clr = (a == 3'd3) && d[0];
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    edge_step(0, clr, 0, 0);
    cfg_we = 1'b0;
    case (a)
      3'd0: begin m_thr_dn = d & 8'hff; m_dn_set = 1; end
      3'd1: begin m_thr_up = d & 8'hff; m_up_set = 1; end
      3'd2: m_settle = d & 8'hff;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) m_hist[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R5 reset level", lvl_req, 2);
    chk("R8 reset irq", irq, 0);
    chk("R1 ready", smp_ready, 1);
    rd_chk(3'd0, 0, "R9 reset down threshold");
    rd_chk(3'd4, 2, "R9 reset level register");

    // R6: request asserted but thresholds unprogrammed: ignored
    run_req_n = 1'b0;
    for (int i = 0; i < 5; i++) send(255, "R6 unprogrammed hold");
    chk("R6 still high", lvl_req, 2);
    wr(3'd0, 150);
    rd_chk(3'd0, 150, "R9 down threshold readback");
    send(255, "R6 one threshold only");
    chk("R6 half armed", lvl_req, 2);

    wr(3'd1, 60);
    wr(3'd2, 3);
    rd_chk(3'd2, 3, "R9 settle readback");
    rd_chk(3'd4, 6, "R9 active and level");
    send(255, "R3 step down");
    chk("R3 down to medium", lvl_req, 1);
    send(255, "R7 blocked while settling");
    chk("R7 no step during settle", lvl_req, 1);
    idle(1);
    chk("R8 irq on expiry", irq, m_irq);
    chk("R8 irq set", irq, 1);
    rd_chk(3'd3, 1, "R9 status bit");
    send(255, "R3 step to low");
    chk("R3 low reached", lvl_req, 0);
    idle(5);
    send(255, "R3 floor suppress");
    chk("R3 stays low", lvl_req, 0);
    wr(3'd3, 1);
    chk("R8 write-one clear", irq, 0);

    // sweep across settle counts, sample patterns and gaps
    for (int t = 0; t < 3; t++) begin
      wr(3'd2, (t == 0) ? 0 : (t == 1) ? 3 : 7);
      for (int i = 0; i < 48; i++) begin
        int s;
        s = ((i >> 3) & 1) ? (i * 29) % 64 : 160 + (i * 13) % 96;
        send(s, "R2 R3 R4 R7 sweep level");
        idle(i % 4);
        chk("R8 sweep irq", irq, m_irq);
        if (i % 16 == 15) begin
          wr(3'd3, 1);
          chk("R8 sweep clear", irq, m_irq);
        end
      end
    end

    // R6: request released, level must hold
    idle(10);
    run_req_n = 1'b1;
    for (int i = 0; i < 4; i++) send(0, "R6 released hold");
    for (int i = 0; i < 4; i++) send(255, "R6 released hold");
    rd_chk(3'd4, m_level, "R9 inactive level register");

    // R4: up wins over down
    run_req_n = 1'b0;
    wr(3'd0, 50);
    wr(3'd1, 0);
    wr(3'd2, 2);
    for (int i = 0; i < 4; i++) begin send(255, "R3 drive to low"); idle(4); end
    chk("R3 low before priority test", lvl_req, 0);
    wr(3'd1, 100);
    send(200, "R4 priority setup"); idle(4);
    send(200, "R4 priority setup"); idle(4);
    send(10, "R4 priority setup"); idle(4);
    send(10, "R4 both conditions");
    chk("R4 up wins", lvl_req, 1);
    idle(4);
    send(0, "R4 up again"); idle(4);
    chk("R4 at high", lvl_req, 2);
    send(0, "R4 ceiling suppress");
    chk("R4 stays high", lvl_req, 2);
    chk("R1 ready end", smp_ready, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule